// File: doc/BRIEF.md
# Sign-Selectable Multiply-Accumulate-Subtract Unit

This block is a two-stage arithmetic pipeline. It multiplies two 18-bit operands and, in the same step, adds the product to a 55-bit running total and subtracts a 54-bit operand from it. Each multiplier operand has its own control bit. When that bit is set, the operand is treated as two's complement. When it is clear, the operand is treated as plain binary. This lets one multiplier serve unsigned, signed and mixed-sign arithmetic.

A caller starts a result with a load step, which ignores the old total. Further accumulate steps then add more terms. The top bit of the total acts as a comparison flag. After a load of A×B with subtrahend C, the flag is 1 exactly when A×B is smaller than C. A valid bit travels with each operation. A clock enable freezes the whole pipeline, and a synchronous reset clears it.

Top module: `macAccSub`

## Requirements
- R1: The product is the low 36 bits of the multiplication of the two operands after each is extended to 36 bits. Operand A is sign-extended when `aSigned`=1 and zero-extended when `aSigned`=0; `bSigned` does the same for operand B.
- R2: Before it is added, the 36-bit product is extended to 55 bits. The extension copies the product's bit 35 when `aSigned` or `bSigned` is 1, and fills with zeros when both are 0. The 54-bit `opC` is always sign-extended to 55 bits.
- R3: An operation with `loadSel`=1 sets the total to extended product minus extended `opC`, and the previous total has no effect.
- R4: An operation with `loadSel`=0 sets the total to the previous total plus extended product minus extended `opC`.
- R5: `negFlag` equals bit 54 of `accOut`. After a load where A×B < C, it reads 1; where A×B ≥ C, it reads 0.
- R6: Operands presented with `inValid`=1 on a rising edge, followed by a second rising edge with `ce`=1, appear on `accOut` after that second edge, with `outValid`=1. A pipeline slot whose `inValid` was 0 leaves `accOut` unchanged and drives `outValid` to 0.
- R7: While `ce`=0, every register holds, so `accOut` and `outValid` stay stable and the inputs presented are discarded.
- R8: `rst`=1 on a rising edge clears `accOut`, `outValid` and the pipeline, even when `ce`=0.
- R9: The total wraps modulo 2^55 without saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| inValid | input | 1 | Operands on this edge form an operation |
| loadSel | input | 1 | 1 = load, 0 = accumulate |
| aSigned | input | 1 | 1 = operand A is two's complement |
| bSigned | input | 1 | 1 = operand B is two's complement |
| opA | input | 18 | Multiplier operand A |
| opB | input | 18 | Multiplier operand B |
| opC | input | 54 | Subtrahend, two's complement |
| accOut | output | 55 | Running total |
| outValid | output | 1 | `accOut` holds a fresh result |
| negFlag | output | 1 | Sign of the total (comparison flag) |

## Verification
Every result is due two enabled rising edges after its operands are driven: one edge captures the operands, and the next updates the total. The driver computes each expected total from the requirement arithmetic and queues it. The monitor samples on falling edges, and pops a queued item only when `outValid` is high and the preceding edge had `ce` high. Results held up by a low `ce` are therefore compared exactly once, at the cycle they are due. Directed checks confirm the empty slot after the first edge, stability while `ce` is low, and the cleared state after reset.

// File: rtl/macPkg.sv
package macPkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic clear;      // synchronous clear of every register
    logic capture;    // load the input stage
    logic accUpdate;  // write the total
    logic loadMode;   // 1: ignore previous total
  } macStrobes_t;
endpackage

// File: rtl/macOpExtend.sv
module macOpExtend #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 36
) (
  input  logic [IN_W-1:0]  din,
  input  logic             isSigned,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;
  logic padBit;
  assign padBit = isSigned & din[IN_W-1];
  assign dout = {{PAD_W{padBit}}, din};
endmodule

// File: rtl/macCtrl.sv
module macCtrl
  import macPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ce,
  input  logic        inValid,
  input  logic        loadSel,
  output macStrobes_t strobes,
  output logic        outValid
);
  logic stageValid;
  logic stageLoad;
  logic outValidR;

  // R6/R7/R8: valid travels with data; ce freezes; rst clears
  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid <= 1'b0;
      stageLoad  <= 1'b0;
      outValidR  <= 1'b0;
    end else if (ce) begin
      stageValid <= inValid;
      stageLoad  <= loadSel;
      outValidR  <= stageValid;
    end
  end

  always_comb begin
    strobes.clear     = rst;
    strobes.capture   = ce & ~rst;
    strobes.accUpdate = ce & stageValid & ~rst;
    strobes.loadMode  = stageLoad;
  end

  assign outValid = outValidR;
endmodule

// File: rtl/macDatapath.sv
module macDatapath
  import macPkg::*;
#(
  parameter int OP_W  = 18,
  parameter int SUB_W = 54,
  parameter int ACC_W = 55
) (
  input  logic             clk,
  input  macStrobes_t      strobes,
  input  logic             aSigned,
  input  logic             bSigned,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  logic [SUB_W-1:0] opC,
  output logic [ACC_W-1:0] accOut
);
  localparam int PROD_W = 2 * OP_W;
  localparam int FULL_W = 2 * PROD_W;
  localparam int NUM_OP = 2;

  logic [OP_W-1:0]  opReg  [NUM_OP];
  logic             sgnReg [NUM_OP];
  logic [PROD_W-1:0] opExt [NUM_OP];
  logic [SUB_W-1:0] cReg;
  logic [ACC_W-1:0] accReg;

  logic [FULL_W-1:0] fullProd;
  logic [PROD_W-1:0] prodLow;
  logic              prodSigned;
  logic [ACC_W-1:0]  prodExt;
  logic [ACC_W-1:0]  cExt;
  logic [ACC_W-1:0]  baseVal;
  logic [ACC_W-1:0]  nextAcc;

  // Input stage
  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      for (int i = 0; i < NUM_OP; i++) begin
        opReg[i]  <= '0;
        sgnReg[i] <= 1'b0;
      end
      cReg <= '0;
    end else if (strobes.capture) begin
      opReg[0]  <= opA;
      opReg[1]  <= opB;
      sgnReg[0] <= aSigned;
      sgnReg[1] <= bSigned;
      cReg      <= opC;
    end
  end

  // R1: per-operand sign or zero extension to double width
  for (genvar g = 0; g < NUM_OP; g++) begin : gExt
    macOpExtend #(.IN_W(OP_W), .OUT_W(PROD_W)) uExt (
      .din      (opReg[g]),
      .isSigned (sgnReg[g]),
      .dout     (opExt[g])
    );
  end

  // R1: one unsigned multiplier, low half kept
  assign fullProd = {{PROD_W{1'b0}}, opExt[0]} * {{PROD_W{1'b0}}, opExt[1]};
  assign prodLow  = fullProd[PROD_W-1:0];

  // R2: extend product and subtrahend to total width
  assign prodSigned = sgnReg[0] | sgnReg[1];
  assign prodExt    = {{(ACC_W-PROD_W){prodSigned & prodLow[PROD_W-1]}}, prodLow};
  assign cExt       = {{(ACC_W-SUB_W){cReg[SUB_W-1]}}, cReg};

  // R3/R4/R9: load or accumulate, wrapping
  assign baseVal = strobes.loadMode ? '0 : accReg;
  assign nextAcc = baseVal + prodExt - cExt;

  always_ff @(posedge clk) begin
    if (strobes.clear) accReg <= '0;
    else if (strobes.accUpdate) accReg <= nextAcc;
  end

  assign accOut = accReg;
endmodule

// File: rtl/macAccSub.sv
module macAccSub
  import macPkg::*;
#(
  parameter int OP_W  = 18,
  parameter int SUB_W = 54,
  parameter int ACC_W = 55
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             inValid,
  input  logic             loadSel,
  input  logic             aSigned,
  input  logic             bSigned,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  logic [SUB_W-1:0] opC,
  output logic [ACC_W-1:0] accOut,
  output logic             outValid,
  output logic             negFlag
);
  macStrobes_t strobes;

  macCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .inValid  (inValid),
    .loadSel  (loadSel),
    .strobes  (strobes),
    .outValid (outValid)
  );

  macDatapath #(.OP_W(OP_W), .SUB_W(SUB_W), .ACC_W(ACC_W)) uData (
    .clk     (clk),
    .strobes (strobes),
    .aSigned (aSigned),
    .bSigned (bSigned),
    .opA     (opA),
    .opB     (opB),
    .opC     (opC),
    .accOut  (accOut)
  );

  // R5: comparison flag is the total's sign
  assign negFlag = accOut[ACC_W-1];
endmodule

// File: rtl/macAccSubChk.sv
module macAccSubChk #(
  parameter int ACC_W = 55
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             inValid,
  input logic [ACC_W-1:0] accOut,
  input logic             outValid
);
  p_hold_acc_r7: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(accOut));

  p_hold_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(outValid));

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && $past(ce) && $past(inValid) && !$past(rst)) |=> outValid);

  p_bubble_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && $past(ce) && !$past(inValid)) |=> !outValid);

  p_bubble_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && $past(ce) && !$past(inValid)) |=> $stable(accOut));
endmodule

bind macAccSub macAccSubChk #(.ACC_W(ACC_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .ce       (ce),
  .inValid  (inValid),
  .accOut   (accOut),
  .outValid (outValid)
);

// File: tb/tb_macAccSub.sv
`timescale 1ns/1ps
module tb_macAccSub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic        inValid = 1'b0;
  logic        loadSel = 1'b0;
  logic        aSigned = 1'b0;
  logic        bSigned = 1'b0;
  logic [17:0] opA = '0;
  logic [17:0] opB = '0;
  logic [53:0] opC = '0;
  logic [54:0] accOut;
  logic        outValid;
  logic        negFlag;

  macAccSub dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [54:0] val;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [54:0] refAcc = '0;
  int          nChecks = 0;
  int          nFails = 0;
  logic        ceAtEdge = 1'b0;
  logic        done = 1'b0;

  always @(posedge clk) ceAtEdge <= ce;

  task automatic check(input bit ok, input string tag, input logic [54:0] act, input logic [54:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1/R2 model of the extended product
  function automatic logic [54:0] modelProd(input logic [17:0] a, input logic [17:0] b,
                                            input bit as, input bit bs);
    longint av, bv, p;
    logic [35:0] pl;
    av = as ? longint'($signed(a)) : longint'({46'd0, a});
    bv = bs ? longint'($signed(b)) : longint'({46'd0, b});
    p  = av * bv;
    pl = p[35:0];
    return ((as || bs) && pl[35]) ? {19'h7FFFF, pl} : {19'h0, pl};
  endfunction

  task automatic drive(input logic [17:0] a, input logic [17:0] b, input logic [53:0] c,
                       input bit as, input bit bs, input bit ld, input string tag);
    expItem_t it;
    logic [54:0] cx;
    ce = 1'b1; inValid = 1'b1; loadSel = ld;
    aSigned = as; bSigned = bs; opA = a; opB = b; opC = c;
    cx = {c[53], c};
    refAcc = (ld ? 55'd0 : refAcc) + modelProd(a, b, as, bs) - cx;
    it.val = refAcc; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0; ce = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare each fresh result
  always @(negedge clk) begin
    if (!rst && outValid && ceAtEdge && !done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected result", accOut, '0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(accOut === it.val, it.tag, accOut, it.val);
        check(negFlag === it.val[54], {"R5 flag ", it.tag}, {54'd0, negFlag}, {54'd0, it.val[54]});
      end
    end
  end

  task automatic finishRun;
    done = 1'b1;
    if (expQ.size() != 0) check(1'b0, "R6 results missing", 55'(expQ.size()), '0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    check(1'b0, "watchdog", '0, '0);
    finishRun();
  end

  initial begin
    logic [54:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0; ce = 1'b1;
    @(negedge clk);
    check(accOut === '0, "R8 reset total", accOut, '0);
    check(outValid === 1'b0, "R8 reset valid", {54'd0, outValid}, '0);

    // R6 latency: result not ready after one edge, ready after two
    drive(18'h3FFFF, 18'h3FFFF, 54'd0, 0, 0, 1, "R1 R3 unsigned max load");
    inValid = 1'b0;
    check(outValid === 1'b0, "R6 one edge", {54'd0, outValid}, '0);
    @(negedge clk);
    check(outValid === 1'b1, "R6 two edges", {54'd0, outValid}, 55'd1);

    drive(18'h3FFFF, 18'h3FFFF, 54'd5, 1, 1, 0, "R1 R4 signed -1*-1 acc");
    drive(18'h20000, 18'h00003, 54'd0, 1, 0, 0, "R1 R2 mixed neg*unsigned");
    drive(18'h20000, 18'h00003, 54'd0, 0, 0, 0, "R2 unsigned zero ext");
    drive(18'h00007, 18'h3FFFE, 54'h3FFFFFFFFFFFF0, 0, 1, 0, "R1 R2 unsigned*neg, neg C");
    drive(18'h20000, 18'h20000, 54'd1, 1, 1, 1, "R1 R3 signed min*min load");
    idle(3);

    // R5 comparison
    drive(18'd100, 18'd200, 54'd20001, 0, 0, 1, "R5 AxB<C");
    drive(18'd100, 18'd200, 54'd20000, 0, 0, 1, "R5 AxB==C");
    drive(18'd100, 18'd200, 54'd19999, 0, 0, 1, "R5 AxB>C");
    idle(3);

    // R6 bubble: invalid slots leave total alone
    held = accOut;
    idle(4);
    check(accOut === held, "R6 bubble hold", accOut, held);

    // R7 ce low freezes everything and drops inputs
    drive(18'd3, 18'd4, 54'd2, 0, 0, 0, "R7 before stall");
    ce = 1'b0; inValid = 1'b1; opA = 18'h1234; opB = 18'h777; opC = 54'd99;
    @(negedge clk);
    held = accOut;
    repeat (3) @(negedge clk);
    check(accOut === held, "R7 total frozen", accOut, held);
    check(outValid === 1'b0, "R7 valid frozen", {54'd0, outValid}, '0);
    idle(4);

    // R9 wrap
    drive(18'd0, 18'd0, 54'h20000000000000, 0, 0, 1, "R9 load 2^53");
    drive(18'd0, 18'd0, 54'h20000000000000, 0, 0, 0, "R9 reach 2^54");
    drive(18'd0, 18'd0, 54'h20000000000000, 0, 0, 0, "R9 beyond");
    drive(18'd0, 18'd0, 54'h20000000000000, 0, 0, 0, "R9 wrap to 0");
    idle(4);

    // R8 reset with ce low
    drive(18'd9, 18'd9, 54'd0, 0, 0, 1, "R3 before reset");
    idle(3);
    ce = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(accOut === '0, "R8 reset under ce low", accOut, '0);
    check(outValid === 1'b0, "R8 valid cleared", {54'd0, outValid}, '0);
    refAcc = '0;
    ce = 1'b1;
    drive(18'd2, 18'd3, 54'd1, 0, 0, 0, "R4 acc after reset");
    idle(4);
    finishRun();
  end
endmodule